// File: doc/BRIEF.md
# Egress Packet Receiver With Idle Filtering and Link Checks

This block sits behind a delineated serial link and collects fixed-length packets that arrive as 32-bit words, one byte per lane across four lanes. A word flagged as packet start opens a packet. The block keeps every word of the packet in a local store, and only once the last word has been taken does it replay the whole packet to a downstream FIFO write port, one word per cycle. The packet length is 16 or 20 words and a configuration bit picks it.

The header byte travels on lane 0 of the first word. It tells idle packets from data packets and carries a 2-bit priority. Idle packets never reach the FIFO. The last word of an idle packet is a trailer that holds one CRC-8 byte per lane. That byte covers everything that lane carried since the previous trailer, so it also protects the data packets sent in between.

The header byte also carries even parity. Both kinds of error feed saturating counters and a one-cycle interrupt pulse, and a mode can drop data packets whose header parity is wrong.

Top module: `egr_pkt_rx`

## Requirements
- R1: A packet is 16 words when `cfg_long` is 0 and 20 words when it is 1. A word is taken when `in_valid` is 1. A taken word with `in_sop` = 1 is word 0, and cycles with `in_valid` = 0 inside a packet only stall it.
- R2: `fifo_wr` stays low until the last word of a packet has been taken. From the next cycle it is high for exactly one packet length of consecutive cycles, and it presents the words in arrival order, with `fifo_sop` on the first and `fifo_eop` on the last.
- R3: The header is byte 0 (`in_word[7:0]`) of word 0. Header bit 7 = 1 marks an idle packet, which causes no `fifo_wr`. During a write, `fifo_pri` equals header bits [1:0].
- R4: Lane k is `in_word[8k+7:8k]`. Each lane runs a CRC-8 (polynomial x^8+x^2+x+1, MSB first, initial value 0x00) over every taken byte of that lane. In the last word of an idle packet, each lane byte is compared with that lane's CRC and the CRC then restarts at 0x00. A mismatch on one or more lanes adds one to `crc_err_cnt`.
- R5: A CRC mismatch raises `irq` for one cycle, the cycle after the trailer is taken, but only when `cfg_crc_en` is 1. The counter counts either way.
- R6: A header whose XOR over its 8 bits is 1 adds one to `par_err_cnt` when its packet completes. It also raises `irq` for one cycle in that cycle unless `cfg_par_mask` is 1.
- R7: With `cfg_drop_bad` = 1, a data packet with a header parity error is not written. With `cfg_drop_bad` = 0, it is written normally.
- R8: Both counters stop at all-ones. `cnt_clr` zeroes both on the next edge, and it wins over an increment on that same edge.
- R9: An `in_sop` word that arrives inside a packet restarts collection at word 0. The unfinished packet is never written, but its bytes still count toward the lane CRCs.
- R10: After reset, `fifo_wr`, `irq` and both counters are 0, and every lane CRC starts at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_long | input | 1 | 0: 16-word packets, 1: 20-word packets |
| cfg_crc_en | input | 1 | Lets CRC mismatches raise the interrupt |
| cfg_par_mask | input | 1 | Masks the parity-error interrupt |
| cfg_drop_bad | input | 1 | Drops data packets with a header parity error |
| cnt_clr | input | 1 | Pulse that zeroes both error counters |
| in_valid | input | 1 | Word on `in_word` is valid |
| in_sop | input | 1 | Valid word is word 0 of a packet |
| in_word | input | 32 | Link word, lane k in bits [8k+7:8k] |
| fifo_wr | output | 1 | FIFO write request |
| fifo_sop | output | 1 | Written word is the first of its packet |
| fifo_eop | output | 1 | Written word is the last of its packet |
| fifo_pri | output | 2 | Priority of the packet being written |
| fifo_data | output | 32 | Word being written |
| crc_err_cnt | output | 8 | Saturating count of idle packets with a CRC mismatch |
| par_err_cnt | output | 8 | Saturating count of header parity errors |
| irq | output | 1 | One-cycle error interrupt |

## Verification
The assertions assume that the configuration inputs do not change while a packet is being collected or replayed. They also assume that a new packet start never overtakes a replay in progress, which holds whenever the link delivers at most one word per cycle. The bench changes configuration only at a negative edge after the previous replay has drained and before the next start word. It drives at most one word per cycle, inserting stall cycles in one case, so the store is never overwritten ahead of the replay. Trailer bytes come from a CRC model that the bench runs over exactly the bytes it has sent.

// File: rtl/egr_pkg.sv
package egr_pkg;

    typedef enum logic {
        RX_HUNT,
        RX_BODY
    } rx_state_e;

    typedef enum logic {
        DR_IDLE,
        DR_SEND
    } dr_state_e;

    localparam int          HDR_IDLE_BIT = 7;
    localparam logic [7:0]  CRC_POLY     = 8'h07;

    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] data);
        logic [7:0] c;
        c = crc ^ data;
        for (int b = 0; b < 8; b++) begin
            c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/egr_lane_crc.sv
module egr_lane_crc
    import egr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       chk,
    input  logic [7:0] din,
    output logic       mismatch
);

    logic [7:0] crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= 8'h00;
        end else if (en) begin
            if (chk) begin
                crc_q <= 8'h00;
            end else begin
                crc_q <= crc8_step(crc_q, din);
            end
        end
    end

    assign mismatch = en && chk && (crc_q != din);

endmodule

// File: rtl/egr_rx_ctrl.sv
module egr_rx_ctrl
    import egr_pkg::*;
#(
    parameter int SHORT_WORDS = 16,
    parameter int LONG_WORDS  = 20,
    parameter int IDX_W       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_long,
    input  logic             in_valid,
    input  logic             in_sop,
    output logic             acc,
    output logic             first,
    output logic             last,
    output logic [IDX_W-1:0] slot
);

    localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_WORDS - 1);
    localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(LONG_WORDS - 1);
    localparam logic [IDX_W-1:0] IDX_ONE    = IDX_W'(1);

    rx_state_e        st_q, st_nx;
    logic [IDX_W-1:0] widx_q, widx_nx;
    logic [IDX_W-1:0] last_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= RX_HUNT;
            widx_q <= '0;
        end else begin
            st_q   <= st_nx;
            widx_q <= widx_nx;
        end
    end

    always_comb begin
        last_idx = cfg_long ? LONG_LAST : SHORT_LAST;
        first    = in_valid && in_sop;
        acc      = in_valid && (in_sop || (st_q == RX_BODY));
        slot     = in_sop ? '0 : widx_q;
        last     = in_valid && !in_sop && (st_q == RX_BODY) && (widx_q >= last_idx);
    end

    always_comb begin
        st_nx   = st_q;
        widx_nx = widx_q;
        unique case (st_q)
            RX_HUNT: begin
                if (first) begin
                    st_nx   = RX_BODY;
                    widx_nx = IDX_ONE;
                end
            end
            RX_BODY: begin
                if (first) begin
                    widx_nx = IDX_ONE;
                end else if (last) begin
                    st_nx   = RX_HUNT;
                    widx_nx = '0;
                end else if (in_valid) begin
                    widx_nx = widx_q + IDX_ONE;
                end
            end
        endcase
    end

endmodule

// File: rtl/egr_pkt_store.sv
module egr_pkt_store
    import egr_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int SHORT_WORDS = 16,
    parameter int LONG_WORDS  = 20,
    parameter int IDX_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_long,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              launch,
    input  logic [1:0]        launch_pri,
    output logic              fifo_wr,
    output logic              fifo_sop,
    output logic              fifo_eop,
    output logic [1:0]        fifo_pri,
    output logic [WORD_W-1:0] fifo_data
);

    localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_WORDS - 1);
    localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(LONG_WORDS - 1);
    localparam logic [IDX_W-1:0] IDX_ONE    = IDX_W'(1);

    logic [WORD_W-1:0] mem [LONG_WORDS];

    dr_state_e        st_q, st_nx;
    logic [IDX_W-1:0] ridx_q, ridx_nx;
    logic [1:0]       pri_q, pri_nx;
    logic [IDX_W-1:0] last_idx;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= DR_IDLE;
            ridx_q <= '0;
            pri_q  <= '0;
        end else begin
            st_q   <= st_nx;
            ridx_q <= ridx_nx;
            pri_q  <= pri_nx;
        end
    end

    always_comb begin
        last_idx = cfg_long ? LONG_LAST : SHORT_LAST;
        st_nx    = st_q;
        ridx_nx  = ridx_q;
        pri_nx   = pri_q;
        if (launch) begin
            st_nx   = DR_SEND;
            ridx_nx = '0;
            pri_nx  = launch_pri;
        end else begin
            unique case (st_q)
                DR_IDLE: ;
                DR_SEND: begin
                    if (ridx_q >= last_idx) begin
                        st_nx   = DR_IDLE;
                        ridx_nx = '0;
                    end else begin
                        ridx_nx = ridx_q + IDX_ONE;
                    end
                end
            endcase
        end
    end

    always_comb begin
        fifo_wr   = (st_q == DR_SEND);
        fifo_sop  = fifo_wr && (ridx_q == '0);
        fifo_eop  = fifo_wr && (ridx_q >= last_idx);
        fifo_pri  = pri_q;
        fifo_data = mem[ridx_q];
    end

endmodule

// File: rtl/egr_sat_cnt.sv
module egr_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc && (count != '1)) begin
            count <= count + ONE;
        end
    end

endmodule

// File: rtl/egr_pkt_rx.sv
module egr_pkt_rx
    import egr_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int SHORT_WORDS = 16,
    parameter int LONG_WORDS  = 20,
    parameter int CNT_W       = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_long,
    input  logic                 cfg_crc_en,
    input  logic                 cfg_par_mask,
    input  logic                 cfg_drop_bad,
    input  logic                 cnt_clr,
    input  logic                 in_valid,
    input  logic                 in_sop,
    input  logic [8*LANES-1:0]   in_word,
    output logic                 fifo_wr,
    output logic                 fifo_sop,
    output logic                 fifo_eop,
    output logic [1:0]           fifo_pri,
    output logic [8*LANES-1:0]   fifo_data,
    output logic [CNT_W-1:0]     crc_err_cnt,
    output logic [CNT_W-1:0]     par_err_cnt,
    output logic                 irq
);

    localparam int WORD_W = 8 * LANES;
    localparam int IDX_W  = $clog2(LONG_WORDS);

    logic             acc, first, last;
    logic [IDX_W-1:0] slot;
    logic [7:0]       hdr_q;
    logic             is_idle, par_bad, trailer, crc_bad, launch;
    logic [LANES-1:0] lane_mis;

    egr_rx_ctrl #(
        .SHORT_WORDS(SHORT_WORDS),
        .LONG_WORDS (LONG_WORDS),
        .IDX_W      (IDX_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_long(cfg_long),
        .in_valid(in_valid),
        .in_sop  (in_sop),
        .acc     (acc),
        .first   (first),
        .last    (last),
        .slot    (slot)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q <= '0;
        end else if (first) begin
            hdr_q <= in_word[7:0];
        end
    end

    assign is_idle = hdr_q[HDR_IDLE_BIT];
    assign par_bad = ^hdr_q;
    assign trailer = last && is_idle;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        egr_lane_crc u_crc (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (acc),
            .chk     (trailer),
            .din     (in_word[8*g +: 8]),
            .mismatch(lane_mis[g])
        );
    end

    assign crc_bad = |lane_mis;
    assign launch  = last && !is_idle && !(par_bad && cfg_drop_bad);

    egr_pkt_store #(
        .WORD_W     (WORD_W),
        .SHORT_WORDS(SHORT_WORDS),
        .LONG_WORDS (LONG_WORDS),
        .IDX_W      (IDX_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_long  (cfg_long),
        .wr_en     (acc),
        .wr_idx    (slot),
        .wr_data   (in_word),
        .launch    (launch),
        .launch_pri(hdr_q[1:0]),
        .fifo_wr   (fifo_wr),
        .fifo_sop  (fifo_sop),
        .fifo_eop  (fifo_eop),
        .fifo_pri  (fifo_pri),
        .fifo_data (fifo_data)
    );

    egr_sat_cnt #(.W(CNT_W)) u_crc_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (crc_bad),
        .count(crc_err_cnt)
    );

    egr_sat_cnt #(.W(CNT_W)) u_par_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (last && par_bad),
        .count(par_err_cnt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= (crc_bad && cfg_crc_en) || (last && par_bad && !cfg_par_mask);
        end
    end

endmodule

// File: rtl/egr_pkt_rx_chk.sv
module egr_pkt_rx_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             cnt_clr,
    input logic             fifo_wr,
    input logic             fifo_sop,
    input logic             fifo_eop,
    input logic             irq,
    input logic [CNT_W-1:0] crc_err_cnt,
    input logic [CNT_W-1:0] par_err_cnt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    a_r2_burst_opens_with_sop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_wr) |-> fifo_sop);

    a_r2_eop_inside_burst: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_eop |-> fifo_wr);

    a_r2_burst_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && !fifo_sop) |-> ($past(fifo_wr) && !$past(fifo_eop)));

    a_r2_back_to_back_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && fifo_sop && $past(fifo_wr)) |-> $past(fifo_eop));

    a_r5_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r6_irq_follows_taken_word: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(in_valid));

    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (crc_err_cnt == '0) && (par_err_cnt == '0));

    a_r8_crc_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        ((crc_err_cnt == '1) && !cnt_clr) |=> (crc_err_cnt == '1));

    a_r8_par_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        ((par_err_cnt == '1) && !cnt_clr) |=> (par_err_cnt == '1));

    a_r8_par_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> ((par_err_cnt == $past(par_err_cnt)) ||
                      (par_err_cnt == $past(par_err_cnt) + ONE)));

    a_r4_crc_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> ((crc_err_cnt == $past(crc_err_cnt)) ||
                      (crc_err_cnt == $past(crc_err_cnt) + ONE)));

endmodule

bind egr_pkt_rx egr_pkt_rx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .cnt_clr    (cnt_clr),
    .fifo_wr    (fifo_wr),
    .fifo_sop   (fifo_sop),
    .fifo_eop   (fifo_eop),
    .irq        (irq),
    .crc_err_cnt(crc_err_cnt),
    .par_err_cnt(par_err_cnt)
);

// File: tb/egr_pkt_rx_bench.sv
`timescale 1ns/1ps
module egr_pkt_rx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_long = 1'b0, cfg_crc_en = 1'b0, cfg_par_mask = 1'b0, cfg_drop_bad = 1'b0;
    logic        cnt_clr = 1'b0, in_valid = 1'b0, in_sop = 1'b0;
    logic [31:0] in_word = '0;
    logic        fifo_wr, fifo_sop, fifo_eop, irq;
    logic [1:0]  fifo_pri;
    logic [31:0] fifo_data;
    logic [7:0]  crc_err_cnt, par_err_cnt;

    always #2 clk = ~clk;

    egr_pkt_rx u_egr_pkt_rx (
        .clk(clk), .rst_n(rst_n), .cfg_long(cfg_long), .cfg_crc_en(cfg_crc_en),
        .cfg_par_mask(cfg_par_mask), .cfg_drop_bad(cfg_drop_bad), .cnt_clr(cnt_clr),
        .in_valid(in_valid), .in_sop(in_sop), .in_word(in_word),
        .fifo_wr(fifo_wr), .fifo_sop(fifo_sop), .fifo_eop(fifo_eop), .fifo_pri(fifo_pri),
        .fifo_data(fifo_data), .crc_err_cnt(crc_err_cnt), .par_err_cnt(par_err_cnt), .irq(irq)
    );

    typedef struct packed {
        logic       lng, idl;
        logic [1:0] pri;
        logic       bpar, cerr, drop, cen, pmask;
        logic       xwr, xirq, xdc, xdp;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0,1'b0,2'd1,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,2'd2,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0},
        '{1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,2'd0,1'b0,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b1,1'b1,1'b0},
        '{1'b0,1'b1,2'd0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0},
        '{1'b0,1'b0,2'd3,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b1},
        '{1'b0,1'b0,2'd0,1'b1,1'b0,1'b1,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b1},
        '{1'b1,1'b0,2'd1,1'b1,1'b0,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b1},
        '{1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,2'd2,1'b0,1'b0,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,2'd0,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0}
    };

    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    int unsigned seed = 32'h1234_5678;
    logic [7:0]  mcrc [4];
    logic [31:0] exp_words [20];
    int          exp_dc = 0;
    int          exp_dp = 0;

    function automatic logic [7:0] ref_crc8(input logic [7:0] c_in, input logic [7:0] d);
        logic [7:0] c;
        c = c_in ^ d;
        for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        return c;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input bit lng, input bit idl, input logic [1:0] pri, input bit bpar,
                        input bit cerr, input bit gap, input bit clrl, input int cut);
        int n = lng ? 20 : 16;
        int m = (cut > 0) ? cut : n;
        logic [7:0]  hdr;
        logic [31:0] w;
        seed = seed * 1664525 + 1013904223;
        hdr       = {idl, 1'b0, seed[13:10], pri};
        hdr[6]    = (^hdr) ^ bpar;
        for (int i = 0; i < m; i++) begin
            seed = seed * 1664525 + 1013904223;
            w = seed;
            if (i == 0) w[7:0] = hdr;
            for (int k = 0; k < 4; k++) begin
                if (idl && (i == n - 1)) begin
                    w[8*k +: 8] = mcrc[k] ^ ((cerr && k == 2) ? 8'h5A : 8'h00);
                    mcrc[k] = 8'h00;
                end else begin
                    mcrc[k] = ref_crc8(mcrc[k], w[8*k +: 8]);
                end
            end
            exp_words[i] = w;
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_word  = w;
            cnt_clr  = clrl && (i == n - 1);
            if (gap && i < m - 1) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_sop   = 1'b0;
            end
        end
    endtask

    task automatic expect_stream(input bit lng, input logic [1:0] pri, input bit xwr, input bit xirq,
                                 input string stag, input string itag);
        int n = lng ? 20 : 16;
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        cnt_clr  = 1'b0;
        chk(itag, irq, xirq);
        for (int k = 0; k < n; k++) begin
            if (xwr)
                chk(stag, {fifo_wr, fifo_sop, fifo_eop, fifo_pri, fifo_data},
                    {1'b1, k == 0, k == n - 1, pri, exp_words[k]});
            else
                chk(stag, fifo_wr, 1'b0);
            @(negedge clk);
        end
        chk("R1 R2 burst length", fifo_wr, 1'b0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) mcrc[k] = 8'h00;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 fifo_wr in reset", fifo_wr, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 counters after reset", {crc_err_cnt, par_err_cnt, irq}, '0);

        // table walk: R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            cfg_long     = VECS[v].lng;
            cfg_crc_en   = VECS[v].cen;
            cfg_par_mask = VECS[v].pmask;
            cfg_drop_bad = VECS[v].drop;
            send(VECS[v].lng, VECS[v].idl, VECS[v].pri, VECS[v].bpar, VECS[v].cerr, 1'b0, 1'b0, 0);
            exp_dc += int'(VECS[v].xdc);
            exp_dp += int'(VECS[v].xdp);
            expect_stream(VECS[v].lng, VECS[v].pri, VECS[v].xwr, VECS[v].xirq,
                          "R2 R3 R7 stream", "R5 R6 irq");
            chk("R4 crc_err_cnt", crc_err_cnt, exp_dc);
            chk("R6 par_err_cnt", par_err_cnt, exp_dp);
        end

        // R1: stalls inside a long packet
        cfg_long = 1'b1; cfg_drop_bad = 1'b0; cfg_par_mask = 1'b0;
        send(1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 0);
        expect_stream(1'b1, 2'd3, 1'b1, 1'b0, "R1 stalled stream", "R1 irq");

        // R9: restart inside a packet
        cfg_long = 1'b0;
        send(1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 6);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 no write of partial", fifo_wr, 1'b0);
        send(1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        expect_stream(1'b0, 2'd2, 1'b1, 1'b0, "R9 restarted stream", "R9 irq");
        send(1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        expect_stream(1'b0, 2'd0, 1'b0, 1'b0, "R4 R9 idle after restart", "R4 R9 irq");
        chk("R4 R9 crc count after restart", crc_err_cnt, exp_dc);

        // R8: saturation of the parity counter
        cfg_par_mask = 1'b1;
        for (int p = 0; p < 260; p++) begin
            send(1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8 par_err_cnt saturated", par_err_cnt, 8'hFF);
        chk("R8 crc_err_cnt untouched", crc_err_cnt, exp_dc);

        // R8: clear wins over a same-edge increment
        send(1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 0);
        @(negedge clk);
        in_valid = 1'b0;
        cnt_clr  = 1'b0;
        chk("R8 clear beats increment", {crc_err_cnt, par_err_cnt}, 16'h0000);
        @(negedge clk);
        chk("R8 stays clear", {crc_err_cnt, par_err_cnt}, 16'h0000);

        // R4: good trailer after a clear, counters stay zero
        cfg_long = 1'b1;
        send(1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        expect_stream(1'b1, 2'd1, 1'b1, 1'b0, "R2 data before trailer", "R5 irq");
        send(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        expect_stream(1'b1, 2'd0, 1'b0, 1'b0, "R3 idle dropped", "R5 irq");
        chk("R4 good trailer count", crc_err_cnt, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule